// File: doc/BRIEF.md
# Dual Event Performance Counter Unit

This peripheral keeps two independent 48-bit event counters for a processor core. The core presents up to 64 single-cycle event strobes. Each counter has its own control word. That word picks one strobe, gates counting with an enable bit and a start bit, and carries a self-clearing clear bit. It also stores a count-clock select flag, which the unit keeps but does not act on.

Software reaches the unit through a simple synchronous register bus. Read data comes back one cycle after the request. Each count is seen as a 16-bit high word and a 32-bit low word. Either word can be written while counting is stopped, to preload a starting value. A read of the low word captures the matching high half, so software that reads low then high gets one consistent 48-bit value even while counting goes on. Counters wrap silently at the top of their range.

Top module: `perf_event_pair`

## Requirements
- R1: After reset, every control word, every count and every captured high half is zero.
- R2: A control write keeps only bit 15 (enable), bit 14 (start), bit 8 (clock select flag) and bits 5:0 (event code). A control read returns those bits in the same positions. All other bits read 0, including bits 31:16 and bit 13.
- R3: A counter adds one on each clock in which both its bit 15 and bit 14 are set and the strobe numbered by its event code is high. Strobes with any other number are ignored.
- R4: The two counters count independently, each from its own event code.
- R5: While bit 15 or bit 14 is clear, the count holds its value whatever the strobes do.
- R6: Writing a control word with bit 13 set zeroes that counter's 48-bit count and leaves the other counter alone.
- R7: A clear and a qualifying event in the same cycle leave the count at zero.
- R8: A write to the high word loads data bits 15:0 into count bits 47:32. A write to the low word loads data bits 31:0 into count bits 31:0. The other half is left unchanged.
- R9: A count of all ones that takes one more event becomes zero.
- R10: A read of the low word captures count bits 47:32. A high-word read returns the value captured by the most recent low-word read of that counter, even if the count has moved on since.
- R11: The register map is: control n at byte address 4n, high word n at 0x10+8n, low word n at 0x14+8n. Read data appears on the clock after the request. Unmapped reads return 0, and unmapped writes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access request this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 6 | Byte address within the unit |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after a read request |
| eventStrobes | input | 64 | One-cycle event strobes from the core |

## Verification
Two pairs of actions can land in the same cycle: a clear with a qualifying event, and a low-word read with an increment. The bench provokes the first by driving a control write with bit 13 in the same cycle as the selected strobe, and then expects a zero count. For the second, it reads the low word of a count whose low half is all ones, lets an event carry into the high half, and then expects the high-word read to return the old captured high half. A fresh low-then-high read pair must then return the carried value.

// File: rtl/pec_pkg.sv
package pec_pkg;
  localparam int SEL_W = 6;
  localparam int EVT_W = 1 << SEL_W;
  localparam int CTRL_W = 16;
  localparam int EN_B = 15;
  localparam int START_B = 14;
  localparam int CLR_B = 13;
  localparam int CLK_B = 8;
  localparam int CTRL_BASE = 'h00;
  localparam int CNT_BASE = 'h10;
  localparam int CTRL_STRIDE = 4;
  localparam int PAIR_STRIDE = 8;
  localparam int LO_OFS = 4;
  localparam logic [CTRL_W-1:0] KEEP_MASK =
    CTRL_W'((1 << EN_B) | (1 << START_B) | (1 << CLK_B) | ((1 << SEL_W) - 1));

  typedef struct packed {
    logic clr;
    logic wrHi;
    logic wrLo;
    logic snap;
    logic inc;
  } cnt_cmd_t;
endpackage

// File: rtl/perf_ctl.sv
module perf_ctl
  import pec_pkg::*;
#(
  parameter int NUM_CNT = 2,
  parameter int CNT_W = 48,
  parameter int HI_W = 16,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               busSel,
  input  logic                               busWr,
  input  logic [ADDR_W-1:0]                  busAddr,
  input  logic [CTRL_W-1:0]                  ctrlWdata,
  input  logic [EVT_W-1:0]                   eventStrobes,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]      cntFlat,
  input  logic [NUM_CNT-1:0][HI_W-1:0]       snapFlat,
  output cnt_cmd_t [NUM_CNT-1:0]             cmd,
  output logic [NUM_CNT-1:0][CTRL_W-1:0]     ctrlFlat,
  output logic [DATA_W-1:0]                  busRdata
);
  localparam int LO_W = CNT_W - HI_W;

  logic isWr, isRd;
  logic [NUM_CNT-1:0] ctrlHit, hiHit, loHit;
  logic [NUM_CNT-1:0][CTRL_W-1:0] ctrlQ;
  logic [DATA_W-1:0] rdNext;

  assign isWr = busSel && busWr;
  assign isRd = busSel && !busWr;

  for (genvar g = 0; g < NUM_CNT; g++) begin : gCtl
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_BASE + g * CTRL_STRIDE);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(CNT_BASE + g * PAIR_STRIDE);
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(CNT_BASE + g * PAIR_STRIDE + LO_OFS);

    assign ctrlHit[g] = busAddr == CTRL_A;
    assign hiHit[g] = busAddr == HI_A;
    assign loHit[g] = busAddr == LO_A;

    always_ff @(posedge clk) begin
      if (!rstN) ctrlQ[g] <= '0;
      else if (isWr && ctrlHit[g]) ctrlQ[g] <= ctrlWdata & KEEP_MASK;
    end

    assign cmd[g].clr = isWr && ctrlHit[g] && ctrlWdata[CLR_B];
    assign cmd[g].wrHi = isWr && hiHit[g];
    assign cmd[g].wrLo = isWr && loHit[g];
    assign cmd[g].snap = isRd && loHit[g];
    assign cmd[g].inc = ctrlQ[g][EN_B] && ctrlQ[g][START_B] &&
                        eventStrobes[ctrlQ[g][SEL_W-1:0]];
  end

  assign ctrlFlat = ctrlQ;

  always_comb begin
    rdNext = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (ctrlHit[i]) rdNext = DATA_W'(ctrlQ[i]);
      if (hiHit[i]) rdNext = DATA_W'(snapFlat[i]);
      if (loHit[i]) rdNext = DATA_W'(cntFlat[i][LO_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) busRdata <= '0;
    else busRdata <= isRd ? rdNext : '0;
  end
endmodule

// File: rtl/perf_dp.sv
module perf_dp
  import pec_pkg::*;
#(
  parameter int NUM_CNT = 2,
  parameter int CNT_W = 48,
  parameter int HI_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  cnt_cmd_t [NUM_CNT-1:0]         cmd,
  input  logic [DATA_W-1:0]              wdata,
  output logic [NUM_CNT-1:0][CNT_W-1:0]  cntFlat,
  output logic [NUM_CNT-1:0][HI_W-1:0]   snapFlat
);
  localparam int LO_W = CNT_W - HI_W;

  for (genvar g = 0; g < NUM_CNT; g++) begin : gCnt
    logic [CNT_W-1:0] countQ;
    logic [HI_W-1:0] snapQ;

    always_ff @(posedge clk) begin
      if (!rstN) countQ <= '0;
      else if (cmd[g].clr) countQ <= '0;
      else if (cmd[g].wrHi) countQ[CNT_W-1:LO_W] <= wdata[HI_W-1:0];
      else if (cmd[g].wrLo) countQ[LO_W-1:0] <= wdata[LO_W-1:0];
      else if (cmd[g].inc) countQ <= countQ + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN) snapQ <= '0;
      else if (cmd[g].snap) snapQ <= countQ[CNT_W-1:LO_W];
    end

    assign cntFlat[g] = countQ;
    assign snapFlat[g] = snapQ;
  end
endmodule

// File: rtl/perf_event_pair.sv
module perf_event_pair
  import pec_pkg::*;
#(
  parameter int NUM_CNT = 2,
  parameter int CNT_W = 48,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [EVT_W-1:0]  eventStrobes
);
  localparam int HI_W = CNT_W - DATA_W;

  cnt_cmd_t [NUM_CNT-1:0] cmd;
  logic [NUM_CNT-1:0][CNT_W-1:0] cntFlat;
  logic [NUM_CNT-1:0][HI_W-1:0] snapFlat;
  logic [NUM_CNT-1:0][CTRL_W-1:0] ctrlFlat;

  perf_ctl #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .HI_W(HI_W), .ADDR_W(ADDR_W),
             .DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .ctrlWdata(busWdata[CTRL_W-1:0]), .eventStrobes(eventStrobes),
    .cntFlat(cntFlat), .snapFlat(snapFlat), .cmd(cmd), .ctrlFlat(ctrlFlat),
    .busRdata(busRdata));

  perf_dp #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .HI_W(HI_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wdata(busWdata),
    .cntFlat(cntFlat), .snapFlat(snapFlat));
endmodule

// File: rtl/perf_event_pair_chk.sv
module perf_event_pair_chk
  import pec_pkg::*;
#(
  parameter int NUM_CNT = 2,
  parameter int CNT_W = 48,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           busSel,
  input logic                           busWr,
  input logic [ADDR_W-1:0]              busAddr,
  input logic [DATA_W-1:0]              busWdata,
  input logic [DATA_W-1:0]              busRdata,
  input logic [NUM_CNT-1:0][CNT_W-1:0]  cntFlat,
  input logic [NUM_CNT-1:0][CTRL_W-1:0] ctrlFlat
);
  logic anyWr;
  assign anyWr = busSel && busWr;

  for (genvar g = 0; g < NUM_CNT; g++) begin : gChk
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_BASE + g * CTRL_STRIDE);
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(CNT_BASE + g * PAIR_STRIDE + LO_OFS);

    // R7
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      (anyWr && busAddr == CTRL_A && busWdata[CLR_B]) |=> cntFlat[g] == '0);

    // R5
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!ctrlFlat[g][EN_B] && !anyWr) |=> $stable(cntFlat[g]));

    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
      !anyWr |=> (cntFlat[g] == $past(cntFlat[g]) ||
                  cntFlat[g] == $past(cntFlat[g]) + 1'b1));

    // R11
    low_read_chk: assert property (@(posedge clk) disable iff (!rstN)
      (busSel && !busWr && busAddr == LO_A) |=>
        busRdata == $past(cntFlat[g][DATA_W-1:0]));

    // R2
    ctrl_read_chk: assert property (@(posedge clk) disable iff (!rstN)
      (busSel && !busWr && busAddr == CTRL_A) |=>
        (busRdata[DATA_W-1:CTRL_W] == '0 && !busRdata[CLR_B]));
  end
endmodule

bind perf_event_pair perf_event_pair_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W),
  .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .busWdata(busWdata), .busRdata(busRdata), .cntFlat(cntFlat), .ctrlFlat(ctrlFlat));

// File: tb/perf_event_pair_tb.sv
module perf_event_pair_tb;
  logic clk = 0;
  logic rstN = 0;
  logic busSel = 0, busWr = 0;
  logic [5:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [63:0] eventStrobes = '0;

  int checks = 0, fails = 0;
  logic [31:0] expQ[$];
  string tagQ[$];
  bit pendRd = 0;
  bit done = 0;

  always #2 clk = ~clk;

  perf_event_pair u_dut (.clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .eventStrobes(eventStrobes));

  // monitor: note read requests at the edge, compare the response half a cycle later
  always @(posedge clk) pendRd = busSel && !busWr;
  always @(negedge clk) begin
    if (pendRd) begin
      logic [31:0] e;
      string t;
      pendRd = 0;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (busRdata !== e) begin
        fails++;
        $display("FAIL %s: got %08h expected %08h", t, busRdata, e);
      end
    end
  end

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWr = 0;
  endtask

  task automatic busRead(input logic [5:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    busSel = 1; busWr = 0; busAddr = a;
    expQ.push_back(e); tagQ.push_back(t);
    @(negedge clk);
    busSel = 0;
  endtask

  task automatic pulse(input int idx, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); eventStrobes[idx] = 1'b1;
      @(negedge clk); eventStrobes = '0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    busRead(6'h00, 32'h0, "R1 ctrl0");
    busRead(6'h14, 32'h0, "R1 low0");
    busRead(6'h18, 32'h0, "R1 high1");
    // R2 control storage and masking
    busWrite(6'h00, 32'hC113);
    busWrite(6'h04, 32'hFFFF_DFFF);
    busRead(6'h04, 32'h0000_C13F, "R2 masked ctrl1");
    busWrite(6'h04, 32'hC001);
    busRead(6'h00, 32'h0000_C113, "R2 ctrl0 readback");
    // R3 / R4 counting on selected events only
    pulse(8'h13, 5);
    pulse(1, 3);
    pulse(8'h24, 2);
    busRead(6'h14, 32'd5, "R3 low0 count");
    busRead(6'h1C, 32'd3, "R4 low1 count");
    // R5 enable or start clear holds the count
    busWrite(6'h00, 32'h4113);
    pulse(8'h13, 4);
    busRead(6'h14, 32'd5, "R5 enable off hold");
    busWrite(6'h00, 32'h8113);
    pulse(8'h13, 2);
    busRead(6'h14, 32'd5, "R5 start off hold");
    busWrite(6'h00, 32'hC113);
    pulse(8'h13, 2);
    busRead(6'h14, 32'd7, "R3 resumed count");
    // R6 clear
    busWrite(6'h00, 32'hE113);
    busRead(6'h14, 32'd0, "R6 cleared");
    busRead(6'h00, 32'h0000_C113, "R6 clear bit reads 0");
    busRead(6'h1C, 32'd3, "R6 other counter kept");
    // R7 clear together with an event
    pulse(8'h13, 3);
    busRead(6'h14, 32'd3, "R7 pre-count");
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = 6'h00; busWdata = 32'hE113;
    eventStrobes[8'h13] = 1'b1;
    @(negedge clk);
    busSel = 0; busWr = 0; eventStrobes = '0;
    busRead(6'h14, 32'd0, "R7 clear beats event");
    // R8 preload
    busWrite(6'h00, 32'h0);
    busWrite(6'h10, 32'hABCD_1234);
    busWrite(6'h14, 32'h89AB_CDEF);
    busRead(6'h14, 32'h89AB_CDEF, "R8 preload low");
    busRead(6'h10, 32'h0000_1234, "R8 preload high");
    // R9 wrap
    busWrite(6'h10, 32'h0000_FFFF);
    busWrite(6'h14, 32'hFFFF_FFFF);
    busWrite(6'h00, 32'hC113);
    pulse(8'h13, 1);
    busRead(6'h14, 32'h0, "R9 wrap low");
    busRead(6'h10, 32'h0, "R9 wrap high");
    // R10 coherent high capture
    busWrite(6'h00, 32'h0);
    busWrite(6'h10, 32'h5);
    busWrite(6'h14, 32'hFFFF_FFFF);
    busWrite(6'h00, 32'hC113);
    busRead(6'h14, 32'hFFFF_FFFF, "R10 low before carry");
    pulse(8'h13, 1);
    busRead(6'h10, 32'h5, "R10 captured high kept");
    busRead(6'h14, 32'h0, "R10 low after carry");
    busRead(6'h10, 32'h6, "R10 high after carry");
    // R11 unmapped accesses
    busWrite(6'h08, 32'hFFFF);
    busWrite(6'h3C, 32'hFFFF_FFFF);
    busRead(6'h00, 32'h0000_C113, "R11 ctrl0 untouched");
    busRead(6'h04, 32'h0000_C001, "R11 ctrl1 untouched");
    busRead(6'h3C, 32'h0, "R11 unmapped read");
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule